// File: doc/BRIEF.md
# Arrival-Order Bus Arbiter

This block shares one bus among four requesters. The requester that asked first gets the bus first. Request and grant lines are active low. Requests may come from other clock domains, so each one passes through a two-stage synchronizer. A request counts as arrived in the clock cycle in which its synchronized copy first shows up. Requests that arrive while the bus is busy wait in an ordered queue. When the current owner lets go of its request, the bus goes to the oldest waiting requester.

When several requests arrive in the same cycle and nobody holds the bus, the block enters them in ascending index order. It then keeps every grant inactive for one settle cycle before granting the lowest index. A shared active-low output enable masks all grants, and the queue keeps tracking arrivals while the grants are masked. A waiting request that is withdrawn leaves the queue, and the other entries keep their relative order. The reset is asserted asynchronously, and its release is expected to be synchronous with the clock.

Top module: `fcfs_bus_arbiter`

## Requirements
- R1: Grant line n answers request line n only, and both are active low. Start from an empty queue with the enable low. When one request alone is driven low between clock edges, its grant goes low after the third rising edge and not before.
- R2: Requests that arrive in different cycles are granted in the order they arrived, whatever their indices.
- R3: When the owner raises its request, its grant rises after the third rising edge. In that same cycle the oldest waiting requester's grant goes low, or no grant is low if none is waiting.
- R4: A grant stays low for as long as its request stays low. Later arrivals and withdrawals do not take it away.
- R5: Requests that arrive in the same cycle are queued lowest index first. If the queue held nobody before them, all grants stay high for one extra cycle before the lowest index is granted.
- R6: A request line held high is never granted. A grant is low only if its request was low three samples earlier.
- R7: While the enable is high, all grants are high. Arrivals and releases are still tracked, so the grant that shows when the enable goes low is the one the queue order selects.
- R8: A waiting request that goes high before it is granted is removed from the queue. The remaining requesters are later served in their original relative order.
- R9: At most one grant line is low in any cycle.
- R10: While reset is low, all grants are high and the queue is cleared. After reset is released, requests that are still low count as new arrivals.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | 4 | Bus requests, active low, may be asynchronous |
| oe_n | input | 1 | Shared grant enable, active low |
| gnt_n | output | 4 | Bus grants, active low, bit n answers request n |

## Verification
The bench drives all fifteen sets of simultaneous requests. A design that skipped the settle cycle would show a grant one cycle early. A design that broke ties wrongly would serve a higher index first. It also drives all twenty-four one-per-cycle arrival orders, which catches a queue that falls back to fixed priority or loses an entry when it compacts. Further cases withdraw a waiting request in the middle of the queue and mask grants while requests arrive. A shifting bug there would skip or reorder the survivors. A stateless gate would hand the bus to the wrong requester when the enable returns.

// File: rtl/fcfs_pkg.sv
package fcfs_pkg;
  // Number of set bits in a vector of up to 32 bits.
  function automatic int unsigned count_set(input logic [31:0] vec);
    int unsigned total;
    total = 0;
    for (int b = 0; b < 32; b++) total += int'(vec[b]);
    return total;
  endfunction
endpackage

// File: rtl/fcfs_req_sync.sv
module fcfs_req_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] req_n,
  output logic [WIDTH-1:0] req_live
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // Stage 0 takes the request in active-high form; later stages shift it along.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = ~req_n;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign req_live = stage_q[STAGES-1];
endmodule

// File: rtl/fcfs_order_queue.sv
module fcfs_order_queue
  import fcfs_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int IDW     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_live,
  output logic [IDW-1:0]     head_id,
  output logic               head_vld,
  output logic               settle
);
  localparam int CNT_W = IDW + 1;

  logic [IDW-1:0]     slot_id_q  [NUM_REQ];
  logic               slot_vld_q [NUM_REQ];
  logic [IDW-1:0]     slot_id_d  [NUM_REQ];
  logic               slot_vld_d [NUM_REQ];
  logic               settle_q, settle_d;
  logic [NUM_REQ-1:0] queued, arrivals, dropped;
  logic               queue_en;

  // Which requesters are already in the queue, and which of those have let go.
  always_comb begin
    queued  = '0;
    dropped = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (slot_vld_q[i]) begin
        queued[slot_id_q[i]] = 1'b1;
        if (!req_live[slot_id_q[i]]) dropped[i] = 1'b1;
      end
    end
    arrivals = req_live & ~queued;
    queue_en = (|arrivals) || (|dropped);
  end

  // Next queue: survivors shift toward the head in their old order, and
  // arrivals are appended after them, lowest index first.
  always_comb begin
    logic [CNT_W-1:0] fill;
    logic [CNT_W-1:0] survivors;
    fill = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      slot_id_d[i]  = '0;
      slot_vld_d[i] = 1'b0;
    end
    for (int i = 0; i < NUM_REQ; i++) begin
      if (slot_vld_q[i] && !dropped[i] && fill < CNT_W'(NUM_REQ)) begin
        slot_id_d[fill[IDW-1:0]]  = slot_id_q[i];
        slot_vld_d[fill[IDW-1:0]] = 1'b1;
        fill = fill + CNT_W'(1);
      end
    end
    survivors = fill;
    for (int j = 0; j < NUM_REQ; j++) begin
      if (arrivals[j] && fill < CNT_W'(NUM_REQ)) begin
        slot_id_d[fill[IDW-1:0]]  = IDW'(j);
        slot_vld_d[fill[IDW-1:0]] = 1'b1;
        fill = fill + CNT_W'(1);
      end
    end
    // A tie entering an empty queue costs one quiet cycle.
    settle_d = (survivors == '0) && (count_set(32'(arrivals)) >= 2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REQ; i++) begin
        slot_id_q[i]  <= '0;
        slot_vld_q[i] <= 1'b0;
      end
    end else if (queue_en) begin
      for (int i = 0; i < NUM_REQ; i++) begin
        slot_id_q[i]  <= slot_id_d[i];
        slot_vld_q[i] <= slot_vld_d[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) settle_q <= 1'b0;
    else        settle_q <= settle_d;
  end

  assign head_id  = slot_id_q[0];
  assign head_vld = slot_vld_q[0];
  assign settle   = settle_q;
endmodule

// File: rtl/fcfs_grant_gate.sv
module fcfs_grant_gate #(
  parameter int NUM_REQ = 4,
  parameter int IDW     = 2
) (
  input  logic [IDW-1:0]     head_id,
  input  logic               head_vld,
  input  logic               settle,
  input  logic               oe_n,
  output logic [NUM_REQ-1:0] gnt_n
);
  logic open_gate;
  assign open_gate = head_vld && !settle && !oe_n;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_line
    assign gnt_n[g] = !(open_gate && head_id == IDW'(g));
  end
endmodule

// File: rtl/fcfs_bus_arbiter.sv
module fcfs_bus_arbiter #(
  parameter int NUM_REQ     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_n,
  input  logic               oe_n,
  output logic [NUM_REQ-1:0] gnt_n
);
  localparam int IDW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic [NUM_REQ-1:0] req_live;
  logic [IDW-1:0]     head_id;
  logic               head_vld;
  logic               settle;

  fcfs_req_sync #(.WIDTH(NUM_REQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .req_live(req_live)
  );

  fcfs_order_queue #(.NUM_REQ(NUM_REQ), .IDW(IDW)) u_queue (
    .clk(clk), .rst_n(rst_n), .req_live(req_live),
    .head_id(head_id), .head_vld(head_vld), .settle(settle)
  );

  fcfs_grant_gate #(.NUM_REQ(NUM_REQ), .IDW(IDW)) u_gate (
    .head_id(head_id), .head_vld(head_vld), .settle(settle),
    .oe_n(oe_n), .gnt_n(gnt_n)
  );
endmodule

// File: rtl/fcfs_arbiter_checker.sv
module fcfs_arbiter_checker #(
  parameter int NUM_REQ = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_REQ-1:0] req_n,
  input logic               oe_n,
  input logic [NUM_REQ-1:0] gnt_n
);
  // R9: never two grants at once
  assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  // R7: a high enable masks every grant
  assert_oe_masks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (gnt_n == '1));

  // Request-to-grant latency is three samples with the default two-stage synchronizer.
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_line
    // R6: a grant needs a request seen three samples earlier
    assert_needs_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !gnt_n[i] |-> !$past(req_n[i], 3));

    // R4: with the enable steadily low, a grant ends only after its request rose
    assert_holder_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n && !$past(oe_n) && !$past(gnt_n[i]) && gnt_n[i]) |-> $past(req_n[i], 3));
  end
endmodule

bind fcfs_bus_arbiter fcfs_arbiter_checker #(.NUM_REQ(NUM_REQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_n(req_n), .oe_n(oe_n), .gnt_n(gnt_n)
);

// File: tb/fcfs_bus_arbiter_test.sv
module fcfs_bus_arbiter_test;
  logic       clk;
  logic       rst_n;
  logic [3:0] req_n;
  logic       oe_n;
  logic [3:0] gnt_n;
  int         n_checks;
  int         n_fails;
  bit         finished;

  fcfs_bus_arbiter #(.NUM_REQ(4), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .oe_n(oe_n), .gnt_n(gnt_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [3:0] only(input int k);
    return 4'hF & ~(4'h1 << k);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input logic [3:0] expv, input string tag);
    n_checks++;
    if (gnt_n !== expv) begin
      n_fails++;
      $display("FAIL %s: gnt_n=%b expected %b", tag, gnt_n, expv);
    end
  endtask

  // Release the owner; its grant holds two more samples, then moves on.
  task automatic release_to(input int who, input logic [3:0] nxt, input string tag);
    req_n[who] = 1'b1;
    tick(2);
    check(only(who), "R4");
    tick(1);
    check(nxt, tag);
  endtask

  initial begin
    n_checks = 0; n_fails = 0; finished = 0;
    rst_n = 1'b0; req_n = 4'hF; oe_n = 1'b0;
    tick(3);
    check(4'hF, "R10");
    rst_n = 1'b1;
    tick(3);
    check(4'hF, "R10");

    // R1 R5 R6: every set of simultaneous requests
    for (int m = 1; m < 16; m++) begin
      int pop;
      int low;
      pop = 0; low = -1;
      for (int b = 0; b < 4; b++) if (m[b]) begin pop++; if (low < 0) low = b; end
      req_n = ~4'(m);
      tick(2);
      check(4'hF, "R1");
      tick(1);
      if (pop >= 2) begin
        check(4'hF, "R5");
        tick(1);
        check(only(low), "R5");
      end else begin
        check(only(low), "R6");
      end
      for (int b = 0; b < 4; b++) if (m[b]) begin
        int nb;
        nb = -1;
        for (int c = 3; c > b; c--) if (m[c]) nb = c;
        release_to(b, (nb < 0) ? 4'hF : only(nb), "R3");
      end
      tick(2);
    end

    // R2: every order of one-per-cycle arrivals
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) begin
          int d;
          if (a == b || a == c || b == c) continue;
          d = 6 - a - b - c;
          req_n[a] = 1'b0; tick(1);
          req_n[b] = 1'b0; tick(1);
          req_n[c] = 1'b0; tick(1);
          req_n[d] = 1'b0;
          check(only(a), "R2");
          release_to(a, only(b), "R2");
          release_to(b, only(c), "R2");
          release_to(c, only(d), "R2");
          release_to(d, 4'hF, "R3");
          tick(2);
        end

    // R8: withdraw a waiting entry from the middle of the queue
    req_n[3] = 1'b0; tick(1);
    req_n[1] = 1'b0; tick(1);
    req_n[0] = 1'b0; tick(1);
    req_n[2] = 1'b0;
    check(only(3), "R8");
    req_n[1] = 1'b1;
    tick(3);
    check(only(3), "R4");
    release_to(3, only(0), "R8");
    release_to(0, only(2), "R8");
    release_to(2, 4'hF, "R8");
    tick(2);

    // R7: arrivals tracked while masked
    oe_n = 1'b1;
    req_n[2] = 1'b0; tick(1);
    req_n[0] = 1'b0;
    tick(4);
    check(4'hF, "R7");
    oe_n = 1'b0; #1;
    check(only(2), "R7");
    oe_n = 1'b1;
    req_n[2] = 1'b1;
    tick(4);
    check(4'hF, "R7");
    oe_n = 1'b0; #1;
    check(only(0), "R7");
    release_to(0, 4'hF, "R3");
    tick(2);

    // R10: reset while owned; held requests re-arrive as a tie
    req_n = 4'b0101;
    tick(4);
    check(only(1), "R5");
    rst_n = 1'b0; #1;
    check(4'hF, "R10");
    tick(1);
    rst_n = 1'b1;
    tick(3);
    check(4'hF, "R10");
    tick(1);
    check(only(1), "R10");
    req_n = 4'hF;
    tick(4);
    check(4'hF, "R3");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule